// File: doc/BRIEF.md
# Page Permission Checker with Referenced/Changed Write-Back

This block takes one 64-bit leaf page table entry that has already been fetched, and decides whether an access may use it. Beside the entry it receives the entry's memory address, the access kind (load, store or instruction fetch), a user-mode flag, a partition-scope flag and a three-bit authority mask. It reports the rights that the access is granted and a two-bit fault cause.

When the access is allowed, the block sets the referenced bit, and for a store also the changed bit. If that alters the entry, the new value is written back to memory through a request/acknowledge port. For every access other than a store, the write right is taken out of the reported rights. A later store to the same page therefore has to come back through the checker, and that pass sets the changed bit.

A caller pulses `start` with all inputs valid and waits for the one-cycle `done_o` pulse. The results stay stable after that pulse until the next accepted start.

Top module: `pte_perm_rc`

## Requirements
- R1: An instruction fetch (access code 2'b10) to an entry whose attribute field, bits [5:4], equals 2'b10 (non-idempotent I/O) grants rights 3'b000. It sets cause bit 0 (guarded no-execute) and writes nothing back.
- R2: In every other case, rights come from the entry's authority field, bits [2:0] (bit 2 read, bit 1 write, bit 0 execute). When the access is not partition-scoped, the privilege bit (bit 3) is set and the requester is in user mode, the granted rights are 3'b000.
- R3: Otherwise, if the requester is in user mode, or the page is privileged, or the access is partition-scoped, the granted rights equal the authority field.
- R4: For a supervisor access in process scope to a non-privileged page, the granted rights are the authority field ANDed with the authority mask input (same bit order).
- R5: A load (2'b00) needs read, a store (2'b01) needs write and a fetch needs execute. If the needed right is not granted, cause bit 1 (protection fault) is set, `fault_o` is high, the reported rights are the granted rights, and nothing is written back.
- R6: On success the updated entry has the referenced bit (bit 8) set. The changed bit (bit 7) is set only for a store. All other bits are unchanged.
- R7: On success for a load or a fetch, the reported rights are the granted rights with the write bit cleared. For a store, they are the granted rights unchanged.
- R8: A write-back of the updated entry to the entry's address is requested exactly when the updated entry differs from the original. The request, its address and its data stay asserted and stable until acknowledged.
- R9: `done_o` is high for exactly one cycle per accepted start. The results hold until the next accepted start. A start that arrives while a check or write-back is in progress is ignored.
- R10: `fault_o` is never high while a write-back request is outstanding.
- R11: After reset, `done_o`, `wb_req_o`, `fault_o`, the rights and the cause are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check; all inputs must be valid in this cycle |
| pte_i | input | 64 | Leaf page table entry |
| pte_addr_i | input | ADDR_W | Memory address of the entry |
| acc_i | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| user_i | input | 1 | Requester is in user mode |
| part_scope_i | input | 1 | Access is partition-scoped |
| amr_i | input | 3 | Authority mask rights {read, write, execute} |
| done_o | output | 1 | One-cycle completion pulse |
| prot_o | output | 3 | Reported rights {read, write, execute} |
| cause_o | output | 2 | Bit 1 protection fault, bit 0 guarded no-execute |
| fault_o | output | 1 | Any cause bit set |
| wb_req_o | output | 1 | Write-back request |
| wb_addr_o | output | ADDR_W | Write-back address |
| wb_data_o | output | 64 | Write-back data (updated entry) |
| wb_ack_i | input | 1 | Write-back acknowledge |

## Verification
The bench builds the block with `ADDR_W` set to 20. This keeps addresses short but leaves them wide enough to give each case its own address.

The bench sweeps every combination of:
- access kind;
- user mode;
- scope;
- privilege bit;
- all eight authority values;
- all eight mask values;
- both an ordinary and an I/O attribute;
- all four starting referenced/changed pairs.

This covers every rights branch, every fault path and both the changed and unchanged write-back outcomes. The acknowledge delay rotates between zero and two cycles. At intervals, a second start is injected during a write-back to show that it is ignored.

// File: rtl/pte_perm_pkg.sv
package pte_perm_pkg;

    localparam int PTE_W      = 64;
    localparam int RW_BITS    = 3;
    localparam int BIT_EX     = 0;
    localparam int BIT_WR     = 1;
    localparam int BIT_RD     = 2;
    localparam int BIT_PRIV   = 3;
    localparam int ATT_LO     = 4;
    localparam int ATT_HI     = 5;
    localparam int BIT_CHG    = 7;
    localparam int BIT_REF    = 8;

    localparam logic [1:0] ATT_NI_IO = 2'b10;

    localparam logic [1:0] ACC_LOAD  = 2'b00;
    localparam logic [1:0] ACC_STORE = 2'b01;
    localparam logic [1:0] ACC_FETCH = 2'b10;

    typedef logic [RW_BITS-1:0] rights_t;

    typedef struct packed {
        logic prot_flt;
        logic guard;
    } cause_t;

    typedef struct packed {
        rights_t rights;
        cause_t  cause;
    } verdict_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WB,
        ST_DONE
    } state_e;

    function automatic rights_t need_rights(input logic [1:0] acc);
        rights_t n;
        n = '0;
        case (acc)
            ACC_STORE: n[BIT_WR] = 1'b1;
            ACC_FETCH: n[BIT_EX] = 1'b1;
            default:   n[BIT_RD] = 1'b1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pte_rights_eval.sv
module pte_rights_eval
    import pte_perm_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       acc,
    input  logic             user,
    input  logic             part_scope,
    input  rights_t          amr,
    output verdict_t         verdict
);

    rights_t eaa;
    rights_t granted;
    logic    ni_io;
    logic    privileged;

    always_comb begin
        eaa        = pte[RW_BITS-1:0];
        ni_io      = (pte[ATT_HI:ATT_LO] == ATT_NI_IO);
        privileged = pte[BIT_PRIV];
        granted    = '0;
        verdict    = '0;
        if (acc == ACC_FETCH && ni_io) begin
            verdict.cause.guard = 1'b1;
        end else begin
            if (!part_scope && privileged && user) begin
                granted = '0;
            end else if (user || privileged || part_scope) begin
                granted = eaa;
            end else begin
                granted = eaa & amr;
            end
            verdict.rights = granted;
            if ((need_rights(acc) & ~granted) != '0) begin
                verdict.cause.prot_flt = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pte_rc_update.sv
module pte_rc_update
    import pte_perm_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       acc,
    input  rights_t          granted,
    output logic [PTE_W-1:0] new_pte,
    output logic             differs,
    output rights_t          reported
);

    logic is_store;

    always_comb begin
        is_store         = (acc == ACC_STORE);
        new_pte          = pte;
        new_pte[BIT_REF] = 1'b1;
        reported         = granted;
        if (is_store) begin
            new_pte[BIT_CHG] = 1'b1;
        end else begin
            reported[BIT_WR] = 1'b0;
        end
        differs = (new_pte != pte);
    end

endmodule

// File: rtl/pte_perm_rc.sv
module pte_perm_rc
    import pte_perm_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [63:0]       pte_i,
    input  logic [ADDR_W-1:0] pte_addr_i,
    input  logic [1:0]        acc_i,
    input  logic              user_i,
    input  logic              part_scope_i,
    input  logic [2:0]        amr_i,
    output logic              done_o,
    output logic [2:0]        prot_o,
    output logic [1:0]        cause_o,
    output logic              fault_o,
    output logic              wb_req_o,
    output logic [ADDR_W-1:0] wb_addr_o,
    output logic [63:0]       wb_data_o,
    input  logic              wb_ack_i
);

    state_e            state;
    logic [PTE_W-1:0]  pte_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        acc_q;
    logic              user_q;
    logic              part_q;
    rights_t           amr_q;
    rights_t           prot_q;
    cause_t            cause_q;
    logic [PTE_W-1:0]  wb_data_q;

    verdict_t          verdict;
    logic [PTE_W-1:0]  upd_pte;
    logic              upd_differs;
    rights_t           upd_rights;
    logic              chk_fault;

    pte_rights_eval u_eval (
        .pte        (pte_q),
        .acc        (acc_q),
        .user       (user_q),
        .part_scope (part_q),
        .amr        (amr_q),
        .verdict    (verdict)
    );

    pte_rc_update u_rc (
        .pte      (pte_q),
        .acc      (acc_q),
        .granted  (verdict.rights),
        .new_pte  (upd_pte),
        .differs  (upd_differs),
        .reported (upd_rights)
    );

    assign chk_fault = verdict.cause.prot_flt | verdict.cause.guard;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pte_q     <= '0;
            addr_q    <= '0;
            acc_q     <= '0;
            user_q    <= 1'b0;
            part_q    <= 1'b0;
            amr_q     <= '0;
            prot_q    <= '0;
            cause_q   <= '0;
            wb_data_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pte_q  <= pte_i;
                        addr_q <= pte_addr_i;
                        acc_q  <= acc_i;
                        user_q <= user_i;
                        part_q <= part_scope_i;
                        amr_q  <= amr_i;
                        state  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    cause_q   <= verdict.cause;
                    wb_data_q <= upd_pte;
                    if (chk_fault) begin
                        prot_q <= verdict.rights;
                        state  <= ST_DONE;
                    end else begin
                        prot_q <= upd_rights;
                        state  <= upd_differs ? ST_WB : ST_DONE;
                    end
                end
                ST_WB: begin
                    if (wb_ack_i) begin
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done_o    = (state == ST_DONE);
    assign wb_req_o  = (state == ST_WB);
    assign wb_addr_o = addr_q;
    assign wb_data_o = wb_data_q;
    assign prot_o    = prot_q;
    assign cause_o   = cause_q;
    assign fault_o   = cause_q.prot_flt | cause_q.guard;

    a_r10_no_fault_during_wb: assert property (@(posedge clk) disable iff (rst)
        wb_req_o |-> !fault_o);

    a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
        (wb_req_o && !wb_ack_i) |=> (wb_req_o && $stable(wb_data_o) && $stable(wb_addr_o)));

    a_r8_wb_changes_entry: assert property (@(posedge clk) disable iff (rst)
        wb_req_o |-> (wb_data_o != pte_q));

    a_r6_ref_written: assert property (@(posedge clk) disable iff (rst)
        wb_req_o |-> wb_data_o[BIT_REF]);

    a_r6_chg_on_store: assert property (@(posedge clk) disable iff (rst)
        (wb_req_o && acc_q == ACC_STORE) |-> wb_data_o[BIT_CHG]);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r9_results_hold: assert property (@(posedge clk) disable iff (rst)
        done_o |=> ($stable(prot_o) && $stable(cause_o)));

    a_r1_guard_no_rights: assert property (@(posedge clk) disable iff (rst)
        (done_o && cause_o[0]) |-> (prot_o == 3'b000));

endmodule

// File: tb/tb_pte_perm_rc.sv
module tb_pte_perm_rc;

    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [63:0]       pte_i = '0;
    logic [ADDR_W-1:0] pte_addr_i = '0;
    logic [1:0]        acc_i = '0;
    logic              user_i = 1'b0;
    logic              part_scope_i = 1'b0;
    logic [2:0]        amr_i = '0;
    logic              done_o;
    logic [2:0]        prot_o;
    logic [1:0]        cause_o;
    logic              fault_o;
    logic              wb_req_o;
    logic [ADDR_W-1:0] wb_addr_o;
    logic [63:0]       wb_data_o;
    logic              wb_ack_i = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pte_perm_rc #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .start(start), .pte_i(pte_i),
        .pte_addr_i(pte_addr_i), .acc_i(acc_i), .user_i(user_i),
        .part_scope_i(part_scope_i), .amr_i(amr_i), .done_o(done_o),
        .prot_o(prot_o), .cause_o(cause_o), .fault_o(fault_o),
        .wb_req_o(wb_req_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
        .wb_ack_i(wb_ack_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic run_case(input logic [63:0] pte, input logic [1:0] acc,
                            input bit u, input bit p, input logic [2:0] amr,
                            input int idx);
        logic [2:0]  r, need, e_prot;
        logic [1:0]  e_cause;
        logic        e_wb;
        logic [63:0] e_data;
        logic [ADDR_W-1:0] e_addr;
        string       rtag;
        bit          seen, got_done;
        int          dly, cnt;
        logic [63:0] cap_data;
        logic [ADDR_W-1:0] cap_addr;
        logic [2:0]  held_prot;
        logic [1:0]  held_cause;

        e_addr = ADDR_W'(idx * 8);
        e_data = pte;
        e_wb   = 1'b0;
        if (acc == 2'b10 && pte[5:4] == 2'b10) begin
            e_prot = 3'b000; e_cause = 2'b01; rtag = "R1";
        end else begin
            if (!p && pte[3] && u) begin
                r = 3'b000; rtag = "R2";
            end else if (u || pte[3] || p) begin
                r = pte[2:0]; rtag = "R3";
            end else begin
                r = pte[2:0] & amr; rtag = "R4";
            end
            need = (acc == 2'b00) ? 3'b100 : (acc == 2'b01) ? 3'b010 : 3'b001;
            if ((need & ~r) != 3'b000) begin
                e_prot = r; e_cause = 2'b10;
            end else begin
                e_cause = 2'b00;
                e_data  = pte | 64'h100 | ((acc == 2'b01) ? 64'h80 : 64'h0);
                e_prot  = (acc == 2'b01) ? r : (r & 3'b101);
                e_wb    = (e_data != pte);
                rtag    = (acc == 2'b01) ? rtag : "R7";
            end
        end

        @(negedge clk);
        pte_i = pte; acc_i = acc; user_i = u; part_scope_i = p;
        amr_i = amr; pte_addr_i = e_addr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0; got_done = 0; cnt = 0; dly = idx % 3;
        cap_data = '0; cap_addr = '0;
        for (int k = 0; k < 40 && !got_done; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (wb_ack_i) begin
                wb_ack_i = 1'b0;
            end else if (wb_req_o) begin
                chk(!fault_o, "R10", "fault during write-back", fault_o, 0);
                if (!seen) begin
                    seen = 1; cap_data = wb_data_o; cap_addr = wb_addr_o;
                    if (idx % 5 == 0) begin
                        start = 1'b1; pte_i = ~pte; acc_i = 2'b00;
                    end
                end else begin
                    chk(wb_data_o == cap_data && wb_addr_o == cap_addr, "R8",
                        "request not stable", wb_data_o, cap_data);
                end
                if (cnt == dly) wb_ack_i = 1'b1;
                else cnt++;
            end
            if (done_o) got_done = 1;
        end
        if (!got_done) begin
            chk(0, "R9", "done never seen", 0, 1);
            return;
        end
        chk(prot_o == e_prot, rtag, "rights", prot_o, e_prot);
        chk(cause_o == e_cause, (e_cause == 2'b01) ? "R1" : "R5", "cause", cause_o, e_cause);
        chk(fault_o == (e_cause != 0), "R5", "fault flag", fault_o, e_cause != 0);
        chk(seen == e_wb, "R8", "write-back occurrence", seen, e_wb);
        if (seen && e_wb) begin
            chk(cap_data == e_data, "R6", "write-back data", cap_data, e_data);
            chk(cap_addr == e_addr, "R8", "write-back address", cap_addr, e_addr);
        end
        held_prot = prot_o; held_cause = cause_o;
        @(negedge clk);
        chk(!done_o, "R9", "done longer than one cycle", done_o, 0);
        chk(prot_o == held_prot && cause_o == held_cause, "R9", "results not held",
            {prot_o, cause_o}, {held_prot, held_cause});
    endtask

    initial begin
        int idx;
        logic [63:0] pte;
        idx = 0;
        repeat (3) @(negedge clk);
        chk(!done_o && !wb_req_o && !fault_o, "R11", "control after reset",
            {done_o, wb_req_o, fault_o}, 0);
        chk(prot_o == 0 && cause_o == 0, "R11", "results after reset",
            {prot_o, cause_o}, 0);
        rst = 1'b0;
        for (int acc = 0; acc < 3; acc++)
            for (int u = 0; u < 2; u++)
                for (int p = 0; p < 2; p++)
                    for (int pv = 0; pv < 2; pv++)
                        for (int e = 0; e < 8; e++)
                            for (int m = 0; m < 8; m++)
                                for (int a = 0; a < 2; a++)
                                    for (int rc = 0; rc < 4; rc++) begin
                                        pte = 64'hA5C3_0F00_0000_0000 | (64'(idx) << 12);
                                        pte[8:7] = 2'(rc);
                                        pte[5:4] = (a == 1) ? 2'b10 : 2'b00;
                                        pte[3]   = pv[0];
                                        pte[2:0] = 3'(e);
                                        run_case(pte, 2'(acc), u[0], p[0], 3'(m), idx);
                                        idx++;
                                    end
        finish_run();
    end

endmodule